// File: doc/BRIEF.md
# Serial Save-Memory Port with Command Responder

This block pairs a host-side control/data port with a behavioural model of a small serial save memory. The host programs a 16-bit control word, then pushes bytes through an 8-bit data port; each data write is one byte exchanged with the memory. The result of that exchange is kept in a registered response byte, which the host can read back at any time.

A keep-select flag in the control word holds the memory's chip select across bytes. The first byte of a held transaction is taken as a command. Later bytes are served by that command: sequential read with a multi-byte big-endian address, setting or clearing the write-enable latch, status read, and identification read. The storage contents are a fixed preload computed from the address, so no array is instantiated. Two enable bits in the control word gate every data access.

Top module: `save_spi_port`

## Requirements
- R1: When a data byte is accepted with keep-select set and the internal hold state clear, that byte becomes the current command, hold is set, the address is cleared, the byte position restarts and the response becomes 0x00.
- R2: An accepted byte with keep-select clear clears the hold state, so the next held byte is a new command. That non-held byte is itself still served by the current command.
- R3: Under command 0x03, the ADDR_BYTES bytes after the command are shifted into the address most-significant byte first, and the response is 0x00 for each of them.
- R4: Under command 0x03, each byte after the address phase returns the preload byte at the current address and then increments the address. The preload byte is ((a mod 256)*5 mod 256) XOR ((a>>5) mod 256). Any address at or above MEM_BYTES (8192 by default) returns 0x00.
- R5: Command 0x06 sets status bit 1 (write-enable latch) and command 0x04 clears it. Both give response 0x00. No other status bit is ever set.
- R6: Command 0x05 returns the status byte and command 0x9F returns 0xFF.
- R7: A control write sets bits 15, 14, 13, 6, 1 and 0 from the written value (mask 0xE043), leaves bit 7 unchanged and clears all other bits. ctrl_rdata shows the register.
- R8: Unless control bits 15 (port enable) and 13 (device select) are both 1, data_rdata reads 0x00 and data writes change no state.
- R9: Control bit 6 is passed to the memory as keep-select with every accepted data byte.
- R10: A byte served under an unrecognised command leaves the response unchanged.
- R11: Reset clears the control word, hold state, command, response and status to zero. The response changes only on an accepted data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write value |
| ctrl_rdata | output | 16 | Current control register |
| data_wr | input | 1 | Data byte write strobe (one exchange) |
| data_wdata | input | 8 | Byte sent to the memory |
| data_rdata | output | 8 | Gated response byte |

## Verification
The checker watches on every cycle the properties that need no history: the control-word masking and the kept bit 7, read gating when the enables are off, the response and status staying still without an accepted write, the response clearing when a command is latched, hold dropping after a non-held byte, and an unknown command leaving the response alone. The address shifting, the preload values, the array boundary at 8192, the write-enable latch seen through a status read, and a non-held byte still being served by the old command all depend on multi-byte sequences. These are shown only by the bench's directed and random transactions, checked against its own model.

// File: rtl/save_spi_pkg.sv
package save_spi_pkg;
  typedef enum logic [7:0] {
    OP_READ      = 8'h03,
    OP_LATCH_CLR = 8'h04,
    OP_STATUS    = 8'h05,
    OP_LATCH_SET = 8'h06,
    OP_IDENT     = 8'h9F
  } save_op_e;

  localparam int EN_BIT   = 15;
  localparam int DEV_BIT  = 13;
  localparam int KEEP_BIT = 6;
  localparam int WEL_BIT  = 1;
  localparam logic [15:0] CTRL_WMASK = 16'hE043;
  localparam logic [15:0] CTRL_HOLD  = 16'h0080;
  localparam logic [7:0]  IDENT_BYTE = 8'hFF;

  function automatic logic [15:0] ctrl_merge(input logic [15:0] cur, input logic [15:0] wr);
    return (cur & CTRL_HOLD) | (wr & CTRL_WMASK);
  endfunction

  function automatic logic [7:0] preload_byte(input logic [31:0] a);
    logic [7:0] p;
    p = a[7:0] * 8'd5;
    return p ^ a[12:5];
  endfunction

  function automatic logic [7:0] fetch_byte(input logic [31:0] a, input logic [31:0] size);
    return (a < size) ? preload_byte(a) : 8'h00;
  endfunction

  function automatic logic known_op(input logic [7:0] c);
    return c == OP_READ || c == OP_LATCH_CLR || c == OP_STATUS ||
           c == OP_LATCH_SET || c == OP_IDENT;
  endfunction
endpackage

// File: rtl/save_ctrl_reg.sv
module save_ctrl_reg
  import save_spi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic [15:0] ctrl,
  output logic        dev_en,
  output logic        keep_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (wr) ctrl <= ctrl_merge(ctrl, wdata);
  end

  assign dev_en   = ctrl[EN_BIT] & ctrl[DEV_BIT];
  assign keep_sel = ctrl[KEEP_BIT];
endmodule

// File: rtl/save_mem_responder.sv
module save_mem_responder
  import save_spi_pkg::*;
#(
  parameter int MEM_BYTES  = 8192,
  parameter int ADDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       keep,
  output logic [7:0] resp,
  output logic [7:0] status,
  output logic       hold,
  output logic [7:0] cmd,
  output logic       cmd_evt
);
  localparam logic [7:0]  POS_END = 8'(ADDR_BYTES + 1);
  localparam logic [31:0] SIZE    = 32'(MEM_BYTES);

  logic [7:0]  pos_q;
  logic [31:0] addr_q;
  logic        addr_phase;

  assign cmd_evt    = byte_vld && keep && !hold;
  assign addr_phase = pos_q < POS_END;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= 1'b0;
      cmd    <= '0;
      resp   <= '0;
      status <= '0;
      pos_q  <= '0;
      addr_q <= '0;
    end else if (byte_vld) begin
      if (!keep) hold <= 1'b0;
      if (cmd_evt) begin
        cmd    <= byte_in;
        hold   <= 1'b1;
        resp   <= 8'h00;
        pos_q  <= 8'd1;
        addr_q <= '0;
      end else begin
        case (cmd)
          OP_READ: begin
            if (addr_phase) begin
              addr_q <= {addr_q[23:0], byte_in};
              resp   <= 8'h00;
              pos_q  <= pos_q + 8'd1;
            end else begin
              resp   <= fetch_byte(addr_q, SIZE);
              addr_q <= addr_q + 32'd1;
            end
          end
          OP_LATCH_CLR: begin
            status[WEL_BIT] <= 1'b0;
            resp <= 8'h00;
          end
          OP_STATUS:    resp <= status;
          OP_LATCH_SET: begin
            status[WEL_BIT] <= 1'b1;
            resp <= 8'h00;
          end
          OP_IDENT:     resp <= IDENT_BYTE;
          default:      resp <= resp;
        endcase
      end
    end
  end
endmodule

// File: rtl/save_spi_port.sv
module save_spi_port
  import save_spi_pkg::*;
#(
  parameter int MEM_BYTES  = 8192,
  parameter int ADDR_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [15:0] ctrl_wdata,
  output logic [15:0] ctrl_rdata,
  input  logic        data_wr,
  input  logic [7:0]  data_wdata,
  output logic [7:0]  data_rdata
);
  logic       dev_en, keep_sel, byte_vld;
  logic [7:0] resp, status, cmd;
  logic       hold, cmd_evt;

  save_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .ctrl(ctrl_rdata), .dev_en(dev_en), .keep_sel(keep_sel)
  );

  assign byte_vld = data_wr & dev_en;

  save_mem_responder #(.MEM_BYTES(MEM_BYTES), .ADDR_BYTES(ADDR_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(data_wdata),
    .keep(keep_sel), .resp(resp), .status(status), .hold(hold),
    .cmd(cmd), .cmd_evt(cmd_evt)
  );

  assign data_rdata = dev_en ? resp : 8'h00;
endmodule

// File: rtl/save_spi_port_chk.sv
module save_spi_port_chk
  import save_spi_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_wr,
  input logic [15:0] ctrl_rdata,
  input logic        data_wr,
  input logic [7:0]  data_rdata,
  input logic [7:0]  resp,
  input logic [7:0]  status,
  input logic        hold,
  input logic [7:0]  cmd,
  input logic        cmd_evt
);
  logic en_now, acc;
  assign en_now = ctrl_rdata[15] && ctrl_rdata[13];
  assign acc    = data_wr && en_now;

  a_r1_cmd_clears_resp: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt |=> (resp == 8'h00 && hold));
  a_r2_hold_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ctrl_rdata[6]) |=> !hold);
  a_r5_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'hFD) == 8'h00);
  a_r7_bit7_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_rdata[7] == $past(ctrl_rdata[7]));
  a_r7_masked_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata & 16'h1F3C) == 16'h0000);
  a_r8_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en_now |-> data_rdata == 8'h00);
  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !en_now) |=> ($stable(resp) && $stable(hold) && $stable(status)));
  a_r10_unknown_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cmd_evt && !known_op(cmd)) |=> $stable(resp));
  a_r11_resp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(resp) && $stable(status)));
endmodule

bind save_spi_port save_spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rdata(ctrl_rdata),
  .data_wr(data_wr), .data_rdata(data_rdata), .resp(resp), .status(status),
  .hold(hold), .cmd(cmd), .cmd_evt(cmd_evt)
);

// File: tb/save_spi_port_test.sv
module save_spi_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM = 8192;
  localparam int AB  = 2;

  logic        clk = 0, rst_n = 0;
  logic        ctrl_wr = 0, data_wr = 0;
  logic [15:0] ctrl_wdata = 0, ctrl_rdata;
  logic [7:0]  data_wdata = 0, data_rdata;

  save_spi_port #(.MEM_BYTES(MEM), .ADDR_BYTES(AB)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
    .data_rdata(data_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_ctrl = 0;
  logic        m_hold = 0;
  logic [7:0]  m_cmd = 0, m_resp = 0, m_stat = 0;
  int unsigned m_pos = 0, m_addr = 0;

  function automatic logic [7:0] exp_mem(int unsigned a);
    if (a >= MEM) return 8'h00;
    return 8'(((a % 256) * 5) % 256) ^ 8'((a >> 5) % 256);
  endfunction

  function automatic logic [7:0] exp_rd();
    return (m_ctrl[15] && m_ctrl[13]) ? m_resp : 8'h00;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_data(logic [7:0] b);
    if (!(m_ctrl[15] && m_ctrl[13])) return;
    if (!m_ctrl[6]) m_hold = 0;
    if (m_ctrl[6] && !m_hold) begin
      m_cmd = b; m_hold = 1; m_resp = 0; m_pos = 1; m_addr = 0;
      return;
    end
    case (m_cmd)
      8'h03: if (m_pos < AB + 1) begin
               m_addr = (m_addr << 8) | b; m_resp = 0; m_pos++;
             end else begin
               m_resp = exp_mem(m_addr); m_addr++;
             end
      8'h04: begin m_stat = m_stat & 8'hFD; m_resp = 0; end
      8'h05: m_resp = m_stat;
      8'h06: begin m_stat = m_stat | 8'h02; m_resp = 0; end
      8'h9F: m_resp = 8'hFF;
      default: ;
    endcase
  endtask

  task automatic wr_ctrl(logic [15:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 0;
    m_ctrl = (m_ctrl & 16'h0080) | (v & 16'hE043);
  endtask

  task automatic xfer(logic [7:0] b);
    @(negedge clk); data_wr = 1; data_wdata = b;
    @(negedge clk); data_wr = 0;
    model_data(b);
  endtask

  task automatic xchk(string req, logic [7:0] b, logic [7:0] exp);
    xfer(b);
    check(req, {8'h00, data_rdata}, {8'h00, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset ctrl", ctrl_rdata, 16'h0000);
    check("R11 reset data", {8'h00, data_rdata}, 16'h0000);

    wr_ctrl(16'hFFFF);
    check("R7 mask", ctrl_rdata, 16'hE043);
    wr_ctrl(16'h0000);
    check("R7 clear", ctrl_rdata, 16'h0000);

    // R1 R3 R4: read from 0x0010
    wr_ctrl(16'hA040);
    xchk("R1 cmd latch", 8'h03, 8'h00);
    xchk("R3 addr hi", 8'h00, 8'h00);
    xchk("R3 addr lo", 8'h10, 8'h00);
    xchk("R4 data 0x10", 8'h5A, exp_mem(16));
    xchk("R4 data 0x11", 8'hA5, exp_mem(17));
    // R2: non-held byte still served by read, then new command
    wr_ctrl(16'hA000);
    xchk("R2 non-held served", 8'h00, exp_mem(18));
    wr_ctrl(16'hA040);
    xchk("R2 new cmd", 8'h06, 8'h00);
    xchk("R5 set latch resp", 8'h00, 8'h00);
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xchk("R6 status cmd", 8'h05, 8'h00);
    xchk("R5 R6 status wel", 8'h00, 8'h02);
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xchk("R5 clear latch", 8'h04, 8'h00);
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xfer(8'h05);
    xchk("R5 status cleared", 8'h00, 8'h00);
    // R4 boundary
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xfer(8'h03); xfer(8'h1F); xfer(8'hFF);
    xchk("R4 last byte", 8'h00, exp_mem(16'h1FFF));
    xchk("R4 out of range", 8'h00, 8'h00);
    // R10 unknown command
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xfer(8'h9F);
    xchk("R6 ident", 8'h00, 8'hFF);
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xchk("R10 unknown latch", 8'h42, 8'h00);
    xchk("R10 unknown keeps", 8'h77, 8'h00);
    // R8 gating, R9 keep-select
    wr_ctrl(16'hA000); xfer(8'h00); wr_ctrl(16'hA040);
    xfer(8'h9F); xfer(8'h00);
    wr_ctrl(16'h2040);
    check("R8 read gated en", {8'h00, data_rdata}, 16'h0000);
    xfer(8'h03);
    wr_ctrl(16'h8040);
    check("R8 read gated dev", {8'h00, data_rdata}, 16'h0000);
    xfer(8'h05);
    wr_ctrl(16'hA040);
    check("R8 R11 resp held", {8'h00, data_rdata}, 16'h00FF);
    xchk("R9 still held", 8'h00, 8'hFF);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 10;
      if (r == 0) begin
        logic [15:0] v;
        v = 16'($urandom);
        if ($urandom % 4 != 0) v = v | 16'hA000;
        wr_ctrl(v);
        check("R7 rand ctrl", ctrl_rdata, m_ctrl);
      end else begin
        logic [7:0] b;
        case ($urandom % 7)
          0: b = 8'h03; 1: b = 8'h04; 2: b = 8'h05; 3: b = 8'h06;
          4: b = 8'h9F; 5: b = 8'($urandom % 64);
          default: b = 8'($urandom);
        endcase
        xfer(b);
        check("R4 rand data", {8'h00, data_rdata}, {8'h00, exp_rd()});
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule